// File: doc/BRIEF.md
# Diagnostic Status Packet Builder

This block assembles the short status packet that a device returns to its host once per service period. A single-cycle build strobe starts a packet. The block then streams the packet one byte per clock, with a valid flag and an end-of-packet flag, and without any backpressure. Each packet begins with an 8-byte diagnostic header and ends with a fixed number of payload bytes. The block does not produce the payload bytes itself: it passes them through from a separate byte input.

The header always carries a two-byte magic signature, a phase marker and an echo of the most recent OUT sequence number. The rest of the header depends on the ping-pong phase.

- An odd-phase packet carries a 16-bit timer stamp and the running OUT-miss count. Both are captured at the strobe.
- An even-phase packet carries an IN sequence number. The block keeps this number itself and advances it on even packets only.

The host can use these fields to detect dropped, duplicated or reordered packets and to measure the spacing between periods.

Top module: `status_pkt_builder`

## Requirements
- R1: While reset is asserted and after it is released, `tx_valid_o` and `tx_last_o` stay low until a build strobe is accepted. The first even-phase packet after reset carries IN sequence value 0x00 in byte 7.
- R2: Bytes 0 and 1 of every packet are 0xBA and 0xBE, in that order.
- R3: Byte 2 is 0xDD when `phase_odd_i` was 1 at the accepted strobe and 0xEE when it was 0.
- R4: Byte 3 equals the value of `out_seq_i` at the accepted strobe.
- R5: In an odd packet, byte 4 is the low byte and byte 5 the high byte of `timer_i` sampled at the strobe. Later changes of `timer_i` during the packet do not alter them. With a timer source that advances 0x5DC0 per period, consecutive odd stamps differ by 0x5DC0.
- R6: In an odd packet, byte 6 equals `miss_cnt_i` at the strobe and byte 7 is 0x00.
- R7: In an even packet, bytes 4, 5 and 6 are 0x00. Byte 7 is the IN sequence value, which advances by one after each even packet and is unchanged by odd packets.
- R8: Bytes 8 to 8+PAY_LEN-1 are taken from `pay_byte_i` in the same cycle in which each one is presented.
- R9: An accepted strobe makes `tx_valid_o` high for exactly 8+PAY_LEN consecutive cycles, starting in the cycle after the strobe. `tx_last_o` is high only in the final one, and `tx_valid_o` is low in the cycle that follows.
- R10: A build strobe that arrives while a packet is being streamed is ignored. It does not change the packet's bytes or length, and it does not start a further packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| build_i | input | 1 | One-cycle request to start a packet |
| phase_odd_i | input | 1 | Ping-pong phase: 1 = odd, 0 = even |
| out_seq_i | input | 8 | Last received OUT sequence number |
| timer_i | input | 16 | Free-running cycle timer |
| miss_cnt_i | input | 8 | OUT misses since reset |
| pay_byte_i | input | 8 | Payload byte for the current payload slot |
| tx_data_o | output | 8 | Streamed packet byte |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is valid |
| tx_last_o | output | 1 | Final byte of the packet |

## Verification
The assertions take each build strobe to be a pulse that is sampled at a clock edge. They also take a strobe raised during streaming as something the block must drop, not as a protocol error. Every other input is free to change on any cycle. The stimulus deliberately inverts the timer, miss count and sequence inputs on every cycle of a packet, which shows that the header fields come from the latched copies. It also raises a second strobe of the opposite phase partway through one packet. The phase order of the directed tests is chosen to show that the IN sequence counter moves on even packets only.

// File: rtl/spb_pkg.sv
package spb_pkg;

    localparam int HDR_LEN   = 8;
    localparam logic [7:0] SIG_HI    = 8'hBA;
    localparam logic [7:0] SIG_LO    = 8'hBE;
    localparam logic [7:0] MARK_ODD  = 8'hDD;
    localparam logic [7:0] MARK_EVEN = 8'hEE;

    typedef struct packed {
        logic        odd;
        logic [7:0]  oseq;
        logic [15:0] stamp;
        logic [7:0]  miss;
        logic [7:0]  iseq;
    } hdr_fields_t;

endpackage

// File: rtl/spb_sequencer.sv
module spb_sequencer #(
    parameter int PKT_LEN = 16,
    localparam int IW = $clog2(PKT_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          build_i,
    output logic          take_o,
    output logic          valid_o,
    output logic          last_o,
    output logic [IW-1:0] idx_o
);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
    } seq_st_t;

    localparam logic [IW-1:0] LAST_IDX = IW'(PKT_LEN - 1);

    seq_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        take_o = build_i && !st_q.busy;
        if (take_o) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
        end else if (st_q.busy) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.busy;
    assign last_o  = st_q.busy && (st_q.idx == LAST_IDX);
    assign idx_o   = st_q.idx;

    // R9
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R9
    stream_runs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o |=> valid_o && (idx_o == $past(idx_o) + 1'b1));

    // R9
    gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !valid_o);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !last_o && build_i |=> idx_o != '0);

endmodule

// File: rtl/spb_capture.sv
module spb_capture
    import spb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic        phase_odd_i,
    input  logic [7:0]  out_seq_i,
    input  logic [15:0] timer_i,
    input  logic [7:0]  miss_cnt_i,
    output hdr_fields_t fields_o
);

    typedef struct packed {
        hdr_fields_t f;
        logic [7:0]  in_ctr;
    } cap_st_t;

    cap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.f.odd  = phase_odd_i;
            st_d.f.oseq = out_seq_i;
            if (phase_odd_i) begin
                st_d.f.stamp = timer_i;
                st_d.f.miss  = miss_cnt_i;
            end else begin
                st_d.f.iseq  = st_q.in_ctr;
                st_d.in_ctr  = st_q.in_ctr + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fields_o = st_q.f;

    // R5
    fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(fields_o));

    // R7
    in_ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !phase_odd_i |=> st_q.in_ctr == $past(st_q.in_ctr) + 8'd1);

    // R7
    in_ctr_odd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && phase_odd_i |=> $stable(st_q.in_ctr));

endmodule

// File: rtl/spb_byte_sel.sv
module spb_byte_sel
    import spb_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx_i,
    input  hdr_fields_t   fields_i,
    input  logic [7:0]    pay_byte_i,
    output logic [7:0]    data_o
);

    logic [7:0] hdr_byte;

    always_comb begin
        hdr_byte = 8'h00;
        unique case (idx_i[2:0])
            3'd0: hdr_byte = SIG_HI;
            3'd1: hdr_byte = SIG_LO;
            3'd2: hdr_byte = fields_i.odd ? MARK_ODD : MARK_EVEN;
            3'd3: hdr_byte = fields_i.oseq;
            3'd4: hdr_byte = fields_i.odd ? fields_i.stamp[7:0]  : 8'h00;
            3'd5: hdr_byte = fields_i.odd ? fields_i.stamp[15:8] : 8'h00;
            3'd6: hdr_byte = fields_i.odd ? fields_i.miss        : 8'h00;
            3'd7: hdr_byte = fields_i.odd ? 8'h00 : fields_i.iseq;
            default: hdr_byte = 8'h00;
        endcase
        data_o = (int'(idx_i) < HDR_LEN) ? hdr_byte : pay_byte_i;
    end

endmodule

// File: rtl/status_pkt_builder.sv
module status_pkt_builder
    import spb_pkg::*;
#(
    parameter int PAY_LEN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        build_i,
    input  logic        phase_odd_i,
    input  logic [7:0]  out_seq_i,
    input  logic [15:0] timer_i,
    input  logic [7:0]  miss_cnt_i,
    input  logic [7:0]  pay_byte_i,
    output logic [7:0]  tx_data_o,
    output logic        tx_valid_o,
    output logic        tx_last_o
);

    localparam int PKT_LEN = HDR_LEN + PAY_LEN;
    localparam int IW      = $clog2(PKT_LEN);

    logic          take;
    logic [IW-1:0] idx;
    hdr_fields_t   fields;
    logic [7:0]    sel_byte;

    spb_sequencer #(.PKT_LEN(PKT_LEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .build_i (build_i),
        .take_o  (take),
        .valid_o (tx_valid_o),
        .last_o  (tx_last_o),
        .idx_o   (idx)
    );

    spb_capture u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .phase_odd_i (phase_odd_i),
        .out_seq_i   (out_seq_i),
        .timer_i     (timer_i),
        .miss_cnt_i  (miss_cnt_i),
        .fields_o    (fields)
    );

    spb_byte_sel #(.IW(IW)) u_sel (
        .idx_i      (idx),
        .fields_i   (fields),
        .pay_byte_i (pay_byte_i),
        .data_o     (sel_byte)
    );

    assign tx_data_o = tx_valid_o ? sel_byte : 8'h00;

    // R2
    first_byte_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tx_valid_o && (tx_data_o == SIG_HI));

    // R3
    phase_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && phase_odd_i |=> ##2 tx_data_o == MARK_ODD);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid_o |-> !tx_last_o && (tx_data_o == 8'h00));

endmodule

// File: tb/status_pkt_builder_tb.sv
module status_pkt_builder_tb;

    localparam int PAY_LEN = 8;
    localparam int PKT_LEN = 8 + PAY_LEN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        build_i = 1'b0;
    logic        phase_odd_i = 1'b0;
    logic [7:0]  out_seq_i = '0;
    logic [15:0] timer_i = '0;
    logic [7:0]  miss_cnt_i = '0;
    logic [7:0]  pay_byte_i = '0;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_last_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0]  exp_iseq = 8'h00;
    logic [15:0] last_stamp = '0;

    always #10 clk = ~clk;

    status_pkt_builder #(.PAY_LEN(PAY_LEN)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .build_i     (build_i),
        .phase_odd_i (phase_odd_i),
        .out_seq_i   (out_seq_i),
        .timer_i     (timer_i),
        .miss_cnt_i  (miss_cnt_i),
        .pay_byte_i  (pay_byte_i),
        .tx_data_o   (tx_data_o),
        .tx_valid_o  (tx_valid_o),
        .tx_last_o   (tx_last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input int i, input bit odd);
        case (i)
            0, 1: return "R2";
            2: return "R3";
            3: return "R4";
            4, 5: return odd ? "R5" : "R7";
            6: return odd ? "R6" : "R7";
            7: return odd ? "R6" : "R7";
            default: return "R8";
        endcase
    endfunction

    // Streams one packet and checks every byte, the framing and the gap after it.
    task automatic run_pkt(input bit odd, input logic [7:0] oseq, input logic [15:0] tmr,
                           input logic [7:0] miss, input bit wiggle, input bit rebuild);
        logic [7:0] exp;
        logic [15:0] stamp;
        @(negedge clk);
        phase_odd_i = odd;
        out_seq_i   = oseq;
        timer_i     = tmr;
        miss_cnt_i  = miss;
        build_i     = 1'b1;
        @(negedge clk);
        build_i = 1'b0;
        stamp = '0;
        for (int i = 0; i < PKT_LEN; i++) begin
            pay_byte_i = 8'(64 + i * 3);
            build_i = rebuild && (i == 2);
            if (rebuild && i == 2) phase_odd_i = ~odd;
            if (wiggle) begin
                timer_i    = ~tmr - 16'(i);
                miss_cnt_i = ~miss;
                out_seq_i  = ~oseq;
            end
            #1;
            case (i)
                0: exp = 8'hBA;
                1: exp = 8'hBE;
                2: exp = odd ? 8'hDD : 8'hEE;
                3: exp = oseq;
                4: exp = odd ? tmr[7:0]  : 8'h00;
                5: exp = odd ? tmr[15:8] : 8'h00;
                6: exp = odd ? miss : 8'h00;
                7: exp = odd ? 8'h00 : exp_iseq;
                default: exp = 8'(64 + i * 3);
            endcase
            if (i == 4) stamp[7:0]  = tx_data_o;
            if (i == 5) stamp[15:8] = tx_data_o;
            chk(tx_valid_o === 1'b1, "R9 valid", int'(tx_valid_o), 1);
            chk(tx_last_o === (i == PKT_LEN - 1), "R9 last", int'(tx_last_o), int'(i == PKT_LEN - 1));
            chk(tx_data_o === exp, req_of(i, odd), int'(tx_data_o), int'(exp));
            @(negedge clk);
            build_i = 1'b0;
        end
        #1;
        chk(tx_valid_o === 1'b0, "R9 gap", int'(tx_valid_o), 0);
        if (rebuild) begin
            repeat (3) begin
                @(negedge clk);
                chk(tx_valid_o === 1'b0, "R10 no extra packet", int'(tx_valid_o), 0);
            end
        end
        if (!odd) exp_iseq = exp_iseq + 8'd1;
        if (odd) last_stamp = stamp;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        build_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(tx_valid_o === 1'b0, "R1 valid in reset", int'(tx_valid_o), 0);
        chk(tx_last_o === 1'b0, "R1 last in reset", int'(tx_last_o), 0);
        @(negedge clk);
        build_i = 1'b0;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx_valid_o === 1'b0, "R1 idle after reset", int'(tx_valid_o), 0);
    endtask

    // R1 R7: the first even packet carries IN sequence 0
    task automatic t_first_even();
        run_pkt(1'b0, 8'h51, 16'h1234, 8'h05, 1'b0, 1'b0);
    endtask

    // R5 R6: odd header fields, inputs wiggled while streaming
    task automatic t_odd_held();
        run_pkt(1'b1, 8'h52, 16'h2079, 8'h05, 1'b1, 1'b0);
    endtask

    // R7: an odd packet between evens leaves the IN counter alone
    task automatic t_even_after_odd();
        run_pkt(1'b0, 8'h53, 16'hFFFF, 8'h07, 1'b1, 1'b0);
        run_pkt(1'b0, 8'h54, 16'h0000, 8'h07, 1'b0, 1'b0);
    endtask

    // R5: stamp spacing of 0x5DC0 between consecutive odd packets
    task automatic t_stride();
        logic [15:0] s0;
        run_pkt(1'b1, 8'h55, 16'hA000, 8'h09, 1'b0, 1'b0);
        s0 = last_stamp;
        run_pkt(1'b1, 8'h56, 16'hA000 + 16'h5DC0, 8'h09, 1'b0, 1'b0);
        chk(16'(last_stamp - s0) == 16'h5DC0, "R5 stride", int'(16'(last_stamp - s0)), 'h5DC0);
    endtask

    // R10: strobe of the other phase arrives mid-packet
    task automatic t_rebuild_ignored();
        run_pkt(1'b1, 8'h60, 16'hBEEF, 8'h11, 1'b0, 1'b1);
        run_pkt(1'b0, 8'h61, 16'h0001, 8'h11, 1'b0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_first_even();
        t_odd_held();
        t_even_after_odd();
        t_stride();
        t_rebuild_ignored();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule